// File: doc/BRIEF.md
# Trigger Overrun and Null-Entry Error Monitor

This block watches eight DMA trigger channels and records when a channel gets a trigger it cannot handle. Each channel keeps a pending flag. A trigger sets the flag and a service acknowledgement clears it. A channel's sticky missed bit is set in three cases:
- a second trigger arrives while the earlier one is still pending;
- a trigger lands on a null transfer entry;
- a null transfer request is serviced.

Software reads the missed bits as a 32-bit status word. It clears them by writing ones to a separate clear register.

The block raises a one-cycle error interrupt when the whole error picture goes from clean to dirty. The error picture is the local missed bits together with a single input that summarises every other error register. A small two-state machine tracks this:
- **QUIET**: no error is outstanding anywhere.
- **RAISED**: at least one error is outstanding.

There are two transitions:
- **FIRE** (QUIET to RAISED) happens when any error is present while the machine is in QUIET. The interrupt pulse is produced during that cycle.
- **DRAIN** (RAISED to QUIET) happens once every error source reads clear.

While the machine stays in RAISED, no further pulse is produced.

Top module: `trig_miss_monitor`

## Requirements
- R1: A trigger on channel n that does not hit a null entry sets that channel's pending flag. A service on channel n clears it. A trigger and a service on the same channel in the same cycle leave the flag set and do not set the missed bit.
- R2: A trigger on channel n while its pending flag is set and no service arrives in that cycle sets missed bit n in the next cycle.
- R3: A trigger on channel n with null_hit_i[n] high sets missed bit n. A pulse on null_svc_i[n] sets missed bit n. A trigger that hits a null entry does not set the pending flag.
- R4: Reading word address 0 returns the missed bits in bits 7:0, where bit n belongs to channel n. Bits 31:8 always read 0. Writes to address 0 change nothing.
- R5: Writing word address 1 clears every missed bit whose data bit is 1 and leaves bits written with 0 unchanged. Reads of address 1, and of any other address except 0, return 0.
- R6: When a set condition and a clear write reach the same missed bit in the same cycle, the bit ends up 1.
- R7: After reset, all missed bits and pending flags are 0 and err_irq_o is low.
- R8: err_irq_o is high for exactly one cycle. That cycle is the first cycle in which any missed bit is set or other_err_i is high, following a cycle in which no missed bit was set and other_err_i was low.
- R9: err_irq_o does not pulse again while any error stays outstanding. It can pulse again only after one cycle with all errors clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NUM_CH | Per-channel trigger pulse |
| svc_i | input | NUM_CH | Per-channel service acknowledgement |
| null_hit_i | input | NUM_CH | Qualifies trig_i: the trigger hit a null entry |
| null_svc_i | input | NUM_CH | A null transfer request was serviced on this channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on the address) |
| other_err_i | input | 1 | High while any other error register holds a set bit |
| err_irq_o | output | 1 | One-cycle error interrupt pulse |

## Verification
The bound checker verifies the following properties on every cycle:
- the interrupt is never wider than one cycle;
- it never follows a cycle that already had an error outstanding;
- a double trigger or a null service always lands in the missed bits;
- a missed bit only falls when a matching clear was written;
- the upper status bits stay zero.

Some behaviours can only be shown by the bench's scenarios, which compare against a reference model:
- a trigger and a service arriving together do not count as a miss;
- writes to the status word and zero-writes to the clear register have no effect;
- the interrupt stays silent during a long stretch of outstanding errors and fires again once everything has been cleared.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

    // Word offsets of the two registers; behaviour depends only on them being distinct.
    localparam int unsigned STATUS_OFS = 0;
    localparam int unsigned CLEAR_OFS  = 1;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/tmm_chan.sv
module tmm_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic svc,
    input  logic null_hit,
    input  logic null_svc,
    input  logic clr,
    output logic pend_q,
    output logic miss_q
);

    logic real_trig;
    logic overrun;
    logic miss_set;

    always_comb begin
        real_trig = trig & ~null_hit;
        // A service in the same cycle consumes the earlier trigger, so no overrun.
        overrun   = trig & pend_q & ~svc;
        miss_set  = overrun | (trig & null_hit) | null_svc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            pend_q <= real_trig | (pend_q & ~svc);
            // Set has priority over a simultaneous clear.
            miss_q <= miss_set | (miss_q & ~clr);
        end
    end

endmodule

// File: rtl/tmm_regif.sv
module tmm_regif #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NUM_CH-1:0] miss_vec,
    output logic [NUM_CH-1:0] clr_mask,
    output logic [DATA_W-1:0] reg_rdata
);
    import tmm_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(CLEAR_OFS);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_CH];

    always_comb begin
        clr_mask = '0;
        if (reg_wr && (reg_addr == A_CLEAR)) begin
            clr_mask = reg_wdata[NUM_CH-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATUS) begin
            reg_rdata[NUM_CH-1:0] = miss_vec;
        end
    end

endmodule

// File: rtl/tmm_irq_fsm.sv
module tmm_irq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic any_err,
    output logic irq
);
    import tmm_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_err)  state_d = IRQ_RAISED;  // FIRE
            IRQ_RAISED: if (!any_err) state_d = IRQ_QUIET;   // DRAIN
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            IRQ_QUIET:  irq = any_err;
            IRQ_RAISED: irq = 1'b0;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_miss_monitor.sv
module trig_miss_monitor #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] trig_i,
    input  logic [NUM_CH-1:0] svc_i,
    input  logic [NUM_CH-1:0] null_hit_i,
    input  logic [NUM_CH-1:0] null_svc_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              other_err_i,
    output logic              err_irq_o
);

    logic [NUM_CH-1:0] pend_vec;
    logic [NUM_CH-1:0] miss_vec;
    logic [NUM_CH-1:0] clr_mask;
    logic              any_err;

    tmm_regif #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .reg_wr    (reg_wr_i),
        .reg_addr  (reg_addr_i),
        .reg_wdata (reg_wdata_i),
        .miss_vec  (miss_vec),
        .clr_mask  (clr_mask),
        .reg_rdata (reg_rdata_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig     (trig_i[g]),
            .svc      (svc_i[g]),
            .null_hit (null_hit_i[g]),
            .null_svc (null_svc_i[g]),
            .clr      (clr_mask[g]),
            .pend_q   (pend_vec[g]),
            .miss_q   (miss_vec[g])
        );
    end

    assign any_err = (|miss_vec) | other_err_i;

    tmm_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_err (any_err),
        .irq     (err_irq_o)
    );

endmodule

// File: rtl/tmm_checker.sv
module tmm_checker #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        trig_i,
    input logic [NUM_CH-1:0]        svc_i,
    input logic [NUM_CH-1:0]        null_svc_i,
    input logic                     reg_wr_i,
    input logic [ADDR_W-1:0]        reg_addr_i,
    input logic [NUM_CH-1:0]        wdata_lo_i,
    input logic [DATA_W-NUM_CH-1:0] rdata_hi_i,
    input logic                     other_err_i,
    input logic                     err_irq_o,
    input logic [NUM_CH-1:0]        pend_vec,
    input logic [NUM_CH-1:0]        miss_vec
);
    import tmm_pkg::*;

    logic [NUM_CH-1:0] wr_clr;
    logic [NUM_CH-1:0] dbl;

    always_comb begin
        wr_clr = (reg_wr_i && (reg_addr_i == ADDR_W'(CLEAR_OFS))) ? wdata_lo_i : '0;
        dbl    = trig_i & pend_vec & ~svc_i;
    end

    // R8
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |=> !err_irq_o);

    // R9
    irq_from_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> ($past(miss_vec) == '0 && !$past(other_err_i)));

    // R2
    double_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl != '0) |=> ((miss_vec & $past(dbl)) == $past(dbl)));

    // R3
    null_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (null_svc_i != '0) |=> ((miss_vec & $past(null_svc_i)) == $past(null_svc_i)));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_vec != '0) |=> (((($past(miss_vec) & ~$past(wr_clr)) & ~miss_vec)) == '0));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_hi_i == '0);

endmodule

bind trig_miss_monitor tmm_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .svc_i       (svc_i),
    .null_svc_i  (null_svc_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .wdata_lo_i  (reg_wdata_i[NUM_CH-1:0]),
    .rdata_hi_i  (reg_rdata_o[DATA_W-1:NUM_CH]),
    .other_err_i (other_err_i),
    .err_irq_o   (err_irq_o),
    .pend_vec    (pend_vec),
    .miss_vec    (miss_vec)
);

// File: tb/trig_miss_monitor_tb.sv
module trig_miss_monitor_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trig_i = '0, svc_i = '0, null_hit_i = '0, null_svc_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        other_err_i = 1'b0;
    logic        err_irq_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] m_pend = '0;
    logic [7:0] m_miss = '0;
    logic       m_quiet = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_miss_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .svc_i(svc_i),
        .null_hit_i(null_hit_i), .null_svc_i(null_svc_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .other_err_i(other_err_i), .err_irq_o(err_irq_o)
    );

    function automatic logic [31:0] exp_rdata(input logic [3:0] a, input logic [7:0] miss);
        return (a == 4'd0) ? {24'h0, miss} : 32'h0;
    endfunction

    function automatic logic exp_irq(input logic quiet, input logic [7:0] miss, input logic oth);
        return quiet && ((miss != 8'h0) || oth);
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] t, input logic [7:0] s, input logic [7:0] nh,
                        input logic [7:0] ns, input logic wr, input logic [3:0] a,
                        input logic [31:0] wd, input logic oth, input string tag);
        logic [7:0] clr;
        logic [7:0] setv;
        trig_i = t; svc_i = s; null_hit_i = nh; null_svc_i = ns;
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd; other_err_i = oth;
        #1;
        check({tag, " rdata"}, reg_rdata_o, exp_rdata(a, m_miss));
        check({tag, " irq"}, {31'h0, err_irq_o}, {31'h0, exp_irq(m_quiet, m_miss, oth)});
        m_quiet = !((m_miss != 8'h0) || oth);
        clr  = (wr && a == 4'd1) ? wd[7:0] : 8'h0;
        setv = (t & (nh | (m_pend & ~s))) | ns;
        m_miss = setv | (m_miss & ~clr);
        m_pend = (t & ~nh) | (m_pend & ~s);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        #1;
        // R7: reset state
        check("R7 rdata in reset", reg_rdata_o, 32'h0);
        check("R7 irq in reset", {31'h0, err_irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R7 after reset");

        // R1: trigger, then trigger with service together, then service
        step(8'h01, 8'h00, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b0, "R1 trig");
        step(8'h01, 8'h01, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b0, "R1 trig+svc");
        step(8'h00, 8'h01, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b0, "R1 svc");
        idle("R1 no miss");
        // R2: double trigger on channel 3, then R8 pulse, R9 no repeat
        step(8'h08, 8'h00, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b0, "R2 first");
        step(8'h08, 8'h00, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b0, "R2 second");
        idle("R8 pulse");
        idle("R9 no repeat");
        // R4: write to status ignored
        step(8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, "R4 write status");
        idle("R4 after write");
        // R5: zero clear keeps bit, clear address reads 0
        step(8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 4'd1, 32'h0, 1'b0, "R5 clear zero");
        idle("R5 kept");
        // R6: set and clear same cycle
        step(8'h0, 8'h0, 8'h0, 8'h08, 1'b1, 4'd1, 32'h08, 1'b0, "R6 set vs clear");
        idle("R6 held");
        // R3: null hit on channel 5
        step(8'h20, 8'h0, 8'h20, 8'h0, 1'b0, 4'd0, 32'h0, 1'b0, "R3 null hit");
        idle("R3 seen");
        step(8'h0, 8'h08, 8'h0, 8'h0, 1'b1, 4'd1, 32'hFF, 1'b0, "R5 clear all");
        idle("R5 cleared");
        // R8: other error alone fires; R9: new miss while outstanding does not
        step(8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b1, "R8 other err");
        step(8'h0, 8'h0, 8'h0, 8'h40, 1'b0, 4'd0, 32'h0, 1'b1, "R9 while outstanding");
        step(8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 4'd0, 32'h0, 1'b1, "R9 silent");
        step(8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 4'd1, 32'h40, 1'b0, "R9 drain");
        idle("R9 quiet");
        step(8'h0, 8'h0, 8'h0, 8'h01, 1'b0, 4'd2, 32'h0, 1'b0, "R5 other addr");
        idle("R8 rearmed");

        // Random traffic: R1 R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] t, s, nh, ns;
            logic wr, oth;
            logic [3:0] a;
            t   = 8'($urandom) & 8'($urandom);
            s   = 8'($urandom) & 8'($urandom);
            nh  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ns  = 8'($urandom) & 8'($urandom) & 8'($urandom) & 8'($urandom);
            wr  = ($urandom % 3) == 0;
            a   = 4'($urandom % 3);
            oth = ($urandom % 16) == 0;
            step(t, s, nh, ns, wr, a, $urandom, oth, "R2 R3 R5 random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule